// File: doc/BRIEF.md
# Four-Channel Fan PWM Generator

This block drives up to four cooling fans with pulse-width modulated outputs. Channels are grouped in pairs, and each pair shares one programmable prescaler that divides the system clock. Each channel then divides that prescaled tick again through its own clock-select code. The result clocks an 8-bit down-counter. The counter runs from a programmed period value down to zero, and the output is compared against a programmed duty value.

Software sets the block up through a simple synchronous write port and a combinational read port. It programs the prescalers, the clock-select codes, a shared control word and three per-channel registers: period, duty and a read-only live count. When software writes a duty value, the block also updates that channel's enable and invert bits. A duty of zero parks the output at a fixed high level. Any other duty starts the channel in its normal polarity.

Each channel is a three-state machine. CH_IDLE means disabled: the counter is held at the period value and the output sits at the invert level. CH_RUN means counting. CH_DONE is reached in one-shot mode after the counter hits zero. The transitions are:
- CH_IDLE to CH_RUN when enable is set.
- CH_RUN to CH_RUN, with a reload, on a tick at zero in auto-reload mode.
- CH_RUN to CH_DONE on a tick at zero in one-shot mode.
- Any state to CH_IDLE when enable is cleared.

Top module: `fanpwm_top`

## Requirements
- R1: After reset the registers read as follows.
  - Prescaler (0x00), clock-select (0x04), control (0x08) and every duty register read 0.
  - Every period register reads 0xFF, every count register reads 0xFF, and all outputs are low.
  - Per-channel registers sit at 0x0C (period), 0x10 (duty) and 0x14 (count), each plus 12 times the channel number.
  - Written registers read back what was written.
- R2: Prescaler bits [7:0] serve channels 0 and 1, and bits [15:8] serve channels 2 and 3. A pair tick occurs every field+1 clocks.
- R3: A prescaler field of 0 stops the pair tick, so the counts of both channels in the pair freeze.
- R4: Clock-select holds a 4-bit code per channel in nibble c (bits 4c+3..4c). The codes divide the pair tick as follows:
  - code 4 divides by 1;
  - codes 0, 1, 2 and 3 divide by 2, 4, 8 and 16;
  - all other codes divide by 1.
- R5: A running channel counts down from period P to 0, one step per channel tick, so one PWM cycle lasts P+1 ticks. In auto-reload mode the counter reloads P after 0.
- R6: The output is high while count <= active duty, so the high time is duty+1 ticks. A duty >= period gives a constant high output.
- R7: The invert bit XORs the output.
- R8: Control bit positions:
  - enable bits are 0, 8, 12 and 16 for channels 0 to 3;
  - invert bits are 2, 10, 14 and 18;
  - auto-reload mode bits are 3, 11, 15 and 19.
  Writing duty 0 clears the channel's enable bit and sets its invert bit. Writing a nonzero duty sets enable and clears invert.
- R9: While a channel is disabled, its count follows the period register and its output equals its invert bit.
- R10: A new duty value takes effect only at the next reload. The cycle in progress completes with the old value.
- R11: With the mode bit clear, a channel runs one cycle and then stops. Its count stays at 0 and its output stays at the invert level.
- R12: The count register returns the channel's live counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one clock per write |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_o | output | 4 | PWM outputs, one per channel |

## Verification
The waveform scoreboard measures high time and full cycle length on four channels at once. Each channel uses a different mix of prescaler field, clock-select code, period and duty. Channel 2 uses field 2 (ratio 3), so a field-as-ratio error shows up there. Channel 1 uses code 0, so a divider fault shows up there, and channel 3 uses inversion, so a polarity fault shows up there.

A duty change made just after a rising edge would shorten the current high pulse if the new value took effect at once. A duty equal to the period checks the constant-high corner. Disable, zero-duty, zero-prescaler and one-shot patterns are read back through the count register and the outputs. These tell a held counter apart from a running one.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;

    localparam int SELW = 4;
    localparam int DIVW = 4;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_DONE = 2'd2
    } ch_state_e;

    localparam int OFS_PRESCALE = 'h00;
    localparam int OFS_CLKSEL   = 'h04;
    localparam int OFS_CTRL     = 'h08;

    function automatic int per_ofs(input int ch);
        return 'h0C + 12 * ch;
    endfunction

    function automatic int duty_ofs(input int ch);
        return 'h10 + 12 * ch;
    endfunction

    function automatic int cnt_ofs(input int ch);
        return 'h14 + 12 * ch;
    endfunction

    // control word: channel 0 at bit 0, later channels at 4*ch+4
    function automatic int en_bit(input int ch);
        return (ch == 0) ? 0 : 4 * ch + 4;
    endfunction

    function automatic int inv_bit(input int ch);
        return en_bit(ch) + 2;
    endfunction

    function automatic int mode_bit(input int ch);
        return en_bit(ch) + 3;
    endfunction

    // divide ratio minus one for a clock-select code
    function automatic logic [DIVW-1:0] div_mask(input logic [SELW-1:0] code);
        logic [DIVW-1:0] m;
        case (code)
            4'd0:    m = 4'd1;
            4'd1:    m = 4'd3;
            4'd2:    m = 4'd7;
            4'd3:    m = 4'd15;
            default: m = 4'd0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fanpwm_regs.sv
module fanpwm_regs
    import fanpwm_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 8,
    parameter int AW  = 8,
    parameter int DW  = 32,
    parameter int PW  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_we,
    input  logic [AW-1:0]                  reg_addr,
    input  logic [DW-1:0]                  reg_wdata,
    output logic [DW-1:0]                  reg_rdata,
    input  logic [NCH-1:0][CW-1:0]         cnt_i,
    output logic [NCH/2-1:0][PW-1:0]       pre_o,
    output logic [NCH-1:0][SELW-1:0]       sel_o,
    output logic [NCH-1:0]                 en_o,
    output logic [NCH-1:0]                 inv_o,
    output logic [NCH-1:0]                 mode_o,
    output logic [NCH-1:0][CW-1:0]         period_o,
    output logic [NCH-1:0][CW-1:0]         duty_o
);

    localparam int NPAIR = NCH / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_o    <= '0;
            sel_o    <= '0;
            en_o     <= '0;
            inv_o    <= '0;
            mode_o   <= '0;
            period_o <= '1;
            duty_o   <= '0;
        end else if (reg_we) begin
            if (reg_addr == AW'(OFS_PRESCALE)) begin
                for (int p = 0; p < NPAIR; p++) begin
                    pre_o[p] <= reg_wdata[p*PW +: PW];
                end
            end
            if (reg_addr == AW'(OFS_CLKSEL)) begin
                for (int c = 0; c < NCH; c++) begin
                    sel_o[c] <= reg_wdata[c*SELW +: SELW];
                end
            end
            if (reg_addr == AW'(OFS_CTRL)) begin
                for (int c = 0; c < NCH; c++) begin
                    en_o[c]   <= reg_wdata[en_bit(c)];
                    inv_o[c]  <= reg_wdata[inv_bit(c)];
                    mode_o[c] <= reg_wdata[mode_bit(c)];
                end
            end
            for (int c = 0; c < NCH; c++) begin
                if (reg_addr == AW'(per_ofs(c))) begin
                    period_o[c] <= reg_wdata[CW-1:0];
                end
                if (reg_addr == AW'(duty_ofs(c))) begin
                    duty_o[c] <= reg_wdata[CW-1:0];
                    // zero duty parks the pin, nonzero starts the channel
                    en_o[c]   <= |reg_wdata[CW-1:0];
                    inv_o[c]  <= ~|reg_wdata[CW-1:0];
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(OFS_PRESCALE)) begin
            for (int p = 0; p < NPAIR; p++) begin
                reg_rdata[p*PW +: PW] = pre_o[p];
            end
        end
        if (reg_addr == AW'(OFS_CLKSEL)) begin
            for (int c = 0; c < NCH; c++) begin
                reg_rdata[c*SELW +: SELW] = sel_o[c];
            end
        end
        if (reg_addr == AW'(OFS_CTRL)) begin
            for (int c = 0; c < NCH; c++) begin
                reg_rdata[en_bit(c)]   = en_o[c];
                reg_rdata[inv_bit(c)]  = inv_o[c];
                reg_rdata[mode_bit(c)] = mode_o[c];
            end
        end
        for (int c = 0; c < NCH; c++) begin
            if (reg_addr == AW'(per_ofs(c)))  reg_rdata[CW-1:0] = period_o[c];
            if (reg_addr == AW'(duty_ofs(c))) reg_rdata[CW-1:0] = duty_o[c];
            if (reg_addr == AW'(cnt_ofs(c)))  reg_rdata[CW-1:0] = cnt_i[c];
        end
    end

endmodule

// File: rtl/fanpwm_prescale.sv
module fanpwm_prescale #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] field_i,
    output logic          tick_o
);

    logic [PW-1:0] cnt_q;

    // field 0 means stopped; otherwise one tick every field+1 clocks
    assign tick_o = (field_i != '0) && (cnt_q == field_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (field_i == '0) begin
            cnt_q <= '0;
        end else if (cnt_q >= field_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/fanpwm_chan.sv
module fanpwm_chan
    import fanpwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pair_tick_i,
    input  logic [SELW-1:0] sel_i,
    input  logic            enable_i,
    input  logic            invert_i,
    input  logic            autoload_i,
    input  logic [CW-1:0]   period_i,
    input  logic [CW-1:0]   duty_i,
    output logic [CW-1:0]   count_o,
    output logic            pwm_o
);

    ch_state_e       st_q, st_nxt;
    logic [DIVW-1:0] dcnt_q;
    logic [DIVW-1:0] mask;
    logic            ch_tick;
    logic            at_zero;
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   act_q;
    logic            pwm_q;

    assign mask    = div_mask(sel_i);
    assign ch_tick = pair_tick_i && ((dcnt_q & mask) == mask);
    assign at_zero = (cnt_q == '0);
    assign count_o = cnt_q;
    assign pwm_o   = pwm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt_q <= '0;
        end else if (pair_tick_i) begin
            dcnt_q <= dcnt_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CH_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            CH_IDLE: begin
                if (enable_i) st_nxt = CH_RUN;
            end
            CH_RUN: begin
                if (!enable_i) begin
                    st_nxt = CH_IDLE;
                end else if (ch_tick && at_zero && !autoload_i) begin
                    st_nxt = CH_DONE;
                end
            end
            CH_DONE: begin
                if (!enable_i) st_nxt = CH_IDLE;
            end
            default: st_nxt = CH_IDLE;
        endcase
    end

    // counter, latched duty and output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
            act_q <= '0;
            pwm_q <= 1'b0;
        end else begin
            unique case (st_q)
                CH_IDLE: begin
                    cnt_q <= period_i;
                    act_q <= duty_i;
                    pwm_q <= invert_i;
                end
                CH_RUN: begin
                    pwm_q <= (cnt_q <= act_q) ^ invert_i;
                    if (ch_tick) begin
                        if (!at_zero) begin
                            cnt_q <= cnt_q - 1'b1;
                        end else if (autoload_i) begin
                            cnt_q <= period_i;
                            act_q <= duty_i;
                        end
                    end
                end
                CH_DONE: begin
                    pwm_q <= invert_i;
                end
                default: begin
                    pwm_q <= invert_i;
                end
            endcase
        end
    end

endmodule

// File: rtl/fanpwm_top.sv
module fanpwm_top
    import fanpwm_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 8,
    parameter int AW  = 8,
    parameter int DW  = 32,
    parameter int PW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic [NCH-1:0] pwm_o
);

    localparam int NPAIR = NCH / 2;

    logic [NPAIR-1:0][PW-1:0]  pre_w;
    logic [NPAIR-1:0]          tick_w;
    logic [NCH-1:0][SELW-1:0]  sel_w;
    logic [NCH-1:0]            en_w;
    logic [NCH-1:0]            inv_w;
    logic [NCH-1:0]            mode_w;
    logic [NCH-1:0][CW-1:0]    period_w;
    logic [NCH-1:0][CW-1:0]    duty_w;
    logic [NCH-1:0][CW-1:0]    cnt_w;

    fanpwm_regs #(
        .NCH(NCH), .CW(CW), .AW(AW), .DW(DW), .PW(PW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cnt_i    (cnt_w),
        .pre_o    (pre_w),
        .sel_o    (sel_w),
        .en_o     (en_w),
        .inv_o    (inv_w),
        .mode_o   (mode_w),
        .period_o (period_w),
        .duty_o   (duty_w)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        fanpwm_prescale #(.PW(PW)) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .field_i(pre_w[p]),
            .tick_o (tick_w[p])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        fanpwm_chan #(.CW(CW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .pair_tick_i(tick_w[c/2]),
            .sel_i      (sel_w[c]),
            .enable_i   (en_w[c]),
            .invert_i   (inv_w[c]),
            .autoload_i (mode_w[c]),
            .period_i   (period_w[c]),
            .duty_i     (duty_w[c]),
            .count_o    (cnt_w[c]),
            .pwm_o      (pwm_o[c])
        );
    end

endmodule

// File: rtl/fanpwm_chk.sv
module fanpwm_chk
    import fanpwm_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 8,
    parameter int AW  = 8,
    parameter int PW  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_we,
    input logic [AW-1:0]            reg_addr,
    input logic [CW-1:0]            wd_lo,
    input logic [NCH-1:0]           en_w,
    input logic [NCH-1:0]           inv_w,
    input logic [NCH-1:0][CW-1:0]   cnt_w,
    input logic [NCH-1:0][CW-1:0]   period_w,
    input logic [NCH/2-1:0][PW-1:0] pre_w,
    input logic [NCH-1:0]           pwm_o
);

    logic [1:0] warm_q;
    logic       ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 1'b1;
    end
    assign ready = (warm_q == 2'd3);

    for (genvar c = 0; c < NCH; c++) begin : g_c
        // R8: a zero duty write parks the channel
        a_r8_zero_duty: assert property (@(posedge clk) disable iff (!rst_n || !ready)
            $past(reg_we && reg_addr == AW'(duty_ofs(c)) && wd_lo == '0)
            |-> (!en_w[c] && inv_w[c]));

        // R8: a nonzero duty write starts the channel
        a_r8_live_duty: assert property (@(posedge clk) disable iff (!rst_n || !ready)
            $past(reg_we && reg_addr == AW'(duty_ofs(c)) && wd_lo != '0)
            |-> (en_w[c] && !inv_w[c]));

        // R9: disabled count tracks the period register
        a_r9_hold_period: assert property (@(posedge clk) disable iff (!rst_n || !ready)
            $past(!en_w[c], 2) |-> (cnt_w[c] == $past(period_w[c])));

        // R9: disabled output sits at the invert level
        a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n || !ready)
            $past(!en_w[c], 2) |-> (pwm_o[c] == $past(inv_w[c])));

        // R3: a zero prescaler field freezes the running count
        a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n || !ready)
            ($past(en_w[c]) && $past(en_w[c], 2) && $past(pre_w[c/2] == '0))
            |-> $stable(cnt_w[c]));
    end

endmodule

bind fanpwm_top fanpwm_chk #(
    .NCH(NCH), .CW(CW), .AW(AW), .PW(PW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .wd_lo   (reg_wdata[CW-1:0]),
    .en_w    (en_w),
    .inv_w   (inv_w),
    .cnt_w   (cnt_w),
    .period_w(period_w),
    .pre_w   (pre_w),
    .pwm_o   (pwm_o)
);

// File: tb/tb_fanpwm_top.sv
module tb_fanpwm_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  pwm_o;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        int    ch;
        int    high;
        int    total;
        string req;
    } wave_t;

    wave_t sbq[$];

    always #10 clk = ~clk;

    fanpwm_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .pwm_o    (pwm_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side of the scoreboard
    task automatic expect_wave(input int ch, input int high, input int total, input string req);
        wave_t w;
        w.ch = ch; w.high = high; w.total = total; w.req = req;
        sbq.push_back(w);
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
    endtask

    // monitor side: measure one full cycle after skipping one
    initial begin
        forever begin
            wave_t w;
            int h;
            int l;
            while (sbq.size() == 0) @(negedge clk);
            w = sbq[0];
            while (pwm_o[w.ch] !== 1'b0) @(negedge clk);
            while (pwm_o[w.ch] !== 1'b1) @(negedge clk);
            while (pwm_o[w.ch] !== 1'b0) @(negedge clk);
            while (pwm_o[w.ch] !== 1'b1) @(negedge clk);
            h = 0;
            while (pwm_o[w.ch] === 1'b1) begin h++; @(negedge clk); end
            l = 0;
            while (pwm_o[w.ch] === 1'b0) begin l++; @(negedge clk); end
            check({w.req, " high"}, h, w.high);
            check({w.req, " cycle"}, h + l, w.total);
            void'(sbq.pop_front());
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        logic [31:0] ctl;
        int h;
        int lows;

        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R1: reset values
        rd(8'h00, v); check("R1 prescale reset", v, 32'h0);
        rd(8'h04, v); check("R1 clksel reset", v, 32'h0);
        rd(8'h08, v); check("R1 ctrl reset", v, 32'h0);
        rd(8'h0C, v); check("R1 period0 reset", v, 32'hFF);
        rd(8'h10, v); check("R1 duty0 reset", v, 32'h0);
        rd(8'h14, v); check("R1 count0 reset", v, 32'hFF);
        check("R1 outputs reset", {28'h0, pwm_o}, 32'h0);

        // set up prescalers, codes, modes
        wr(8'h00, 32'h0000_0201);
        wr(8'h04, 32'h0000_4104);
        ctl = 32'h0008_8808;
        wr(8'h08, ctl);
        rd(8'h04, v); check("R1 clksel readback", v, 32'h4104);
        rd(8'h08, v); check("R1 ctrl readback", v, ctl);
        wr(8'h0C, 9); wr(8'h18, 9); wr(8'h24, 4); wr(8'h30, 7);
        wr(8'h10, 3); wr(8'h1C, 5); wr(8'h28, 1); wr(8'h34, 2);
        ctl = ctl | 32'h0001_1101;
        rd(8'h08, v); check("R8 enables set by duty", v, ctl);
        ctl = ctl | 32'h0004_0000;
        wr(8'h08, ctl);
        rd(8'h24, v); check("R1 period2 readback", v, 32'h4);

        // ratios: ch0 2 clk/tick, ch1 4, ch2 12, ch3 3
        expect_wave(0, 8, 20, "R5 R6 ch0");
        expect_wave(1, 24, 40, "R4 ch1 div2");
        expect_wave(2, 24, 60, "R2 ch2 prescale3 div4");
        expect_wave(3, 15, 24, "R7 ch3 inverted");
        drain();

        // R12: live count moves and stays in range
        rd(8'h14, v);
        idle(3);
        rd(8'h14, v2);
        check("R12 live count", {31'h0, (v <= 9 && v2 <= 9 && v != v2)}, 32'h1);

        // R6: duty equal to period gives constant high
        wr(8'h1C, 9);
        idle(100);
        lows = 0;
        for (int i = 0; i < 60; i++) begin
            if (pwm_o[1] !== 1'b1) lows++;
            @(negedge clk);
        end
        check("R6 full duty low samples", lows, 0);

        // R10: duty change mid-cycle waits for reload
        wr(8'h10, 6);
        idle(60);
        while (pwm_o[0] !== 1'b0) @(negedge clk);
        while (pwm_o[0] !== 1'b1) @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h10; reg_wdata = 32'd2;
        h = 1;
        @(negedge clk);
        reg_we = 1'b0;
        while (pwm_o[0] === 1'b1) begin h++; @(negedge clk); end
        check("R10 old duty completes", h, 14);
        expect_wave(0, 6, 20, "R10 new duty after reload");
        drain();

        // R9: disabled channel holds period and invert level
        ctl = ctl & ~32'h1;
        wr(8'h08, ctl);
        idle(5);
        rd(8'h14, v); check("R9 count held", v, 32'd9);
        check("R9 idle level low", {31'h0, pwm_o[0]}, 32'h0);
        wr(8'h0C, 32'h21);
        idle(3);
        rd(8'h14, v); check("R9 count follows period", v, 32'h21);
        ctl = ctl | 32'h4;
        wr(8'h08, ctl);
        idle(3);
        check("R9 idle level inverted", {31'h0, pwm_o[0]}, 32'h1);

        // R8: zero duty parks channel 1 high
        wr(8'h1C, 0);
        ctl = (ctl & ~32'h100) | 32'h400;
        rd(8'h08, v); check("R8 zero duty ctrl", v, ctl);
        idle(5);
        check("R8 zero duty level", {31'h0, pwm_o[1]}, 32'h1);

        // R3: zero field for the upper pair freezes channel 2
        wr(8'h00, 32'h0000_0001);
        idle(5);
        rd(8'h2C, v);
        idle(40);
        rd(8'h2C, v2);
        check("R3 count frozen", v2, v);
        wr(8'h00, 32'h0000_0201);

        // R11: one-shot on channel 2
        ctl = ctl & ~32'h8000;
        wr(8'h08, ctl);
        idle(200);
        rd(8'h2C, v); check("R11 one-shot count", v, 32'h0);
        check("R11 one-shot level", {31'h0, pwm_o[2]}, 32'h0);
        idle(50);
        rd(8'h2C, v); check("R11 one-shot stays", v, 32'h0);

        finish_up();
    end

endmodule